// File: doc/BRIEF.md
# UART Line-Status Flags and Error Interrupt

This block keeps the line-status view of a 16550-style UART. It holds the transmit queue and the transmit shift register's occupancy, and from them it derives two flags. The first says that the holding stage is empty. The second says that the whole transmitter is idle. It also holds the receive queue, in which every character carries three error tags: parity, framing and break. It raises a sticky error flag while any tagged character is still stored. The line-status interrupt comes from the same logic, and a mode input decides when a bad character triggers it.

The serialiser, the baud timing and the bus decoder sit outside the block. The transmit side takes the head byte into the shift register whenever the shift register is free. The serialiser then reports the end of a character with a one-cycle done strobe. Host writes, host reads of receive data and host reads of the status register each arrive as a one-cycle strobe. A push into a full queue is ignored, and so is a pop from an empty queue.

Top module: `uart_line_status`

## Requirements
- R1: After reset, `thr_empty`=1, `tx_empty`=1, `rx_fifo_err`=0, `line_irq`=0, and both levels are 0.
- R2: With `fifo_mode`=1 the transmit queue holds up to DEPTH bytes. `thr_empty` is 1 exactly when `tx_level` is 0, and it goes to 0 on the clock edge that accepts a host write.
- R3: With `fifo_mode`=0 both queues hold at most one entry. `thr_empty` clears on the edge that accepts the write, and it sets again on the edge where that byte moves into the shift register.
- R4: When the shift register is free and the transmit queue is not empty, the head byte moves into the shift register on the next edge, where it appears on `tx_shift_byte`. A `tsr_done` strobe frees the shift register. Bytes leave in the order they were written.
- R5: `tx_empty` is 1 only when the transmit queue is empty and the shift register is free.
- R6: `rx_fifo_err` is 1 while at least one stored receive entry has a nonzero tag. It drops on the edge that pops the last such entry. The tag bits are bit 0 parity, bit 1 framing and bit 2 break.
- R7: `line_irq` is 0 whenever `irq_en` is 0. A pending error event survives while the interrupt is disabled, and it shows again once `irq_en` returns to 1.
- R8: With `early_err`=0, an error event is recorded on the edge after a tagged entry becomes the queue head. `line_irq` is 1 from then until a status read.
- R9: With `early_err`=1, an accepted tagged push records an event on its own edge, and a status read clears it. If that entry later becomes the head, a second event fires. An entry pushed into an empty queue counts as a single event.
- R10: A write to a full transmit queue, a push to a full receive queue and a pop from an empty receive queue all leave every level, flag and interrupt unchanged. A rejected tagged push raises no event.
- R11: When an error event and a status read fall in the same cycle, the event wins and `line_irq` stays 1.
- R12: Receive data and tags leave in arrival order on `rx_rdata` and `rx_rtag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1: queues of DEPTH entries, 0: single holding register |
| irq_en | input | 1 | Line-status interrupt enable |
| early_err | input | 1 | 1: error event when a bad character arrives, 0: when it reaches the head |
| tx_wr | input | 1 | Host write strobe for transmit data |
| tx_wdata | input | DATA_W | Host transmit byte |
| tsr_done | input | 1 | Shift register has finished its character |
| rx_push | input | 1 | Received character strobe |
| rx_wdata | input | DATA_W | Received character |
| rx_wtag | input | 3 | Received tags: bit0 parity, bit1 framing, bit2 break |
| rx_rd | input | 1 | Host read of receive data (pops the head) |
| lsr_rd | input | 1 | Host read of the line-status register |
| tx_level | output | $clog2(DEPTH+1) | Bytes waiting in the transmit queue |
| tx_shift_byte | output | DATA_W | Byte last moved into the shift register |
| thr_empty | output | 1 | Holding stage empty |
| tx_empty | output | 1 | Holding stage and shift register both empty |
| rx_level | output | $clog2(DEPTH+1) | Entries in the receive queue |
| rx_rdata | output | DATA_W | Receive head data |
| rx_rtag | output | 3 | Receive head tags |
| rx_fifo_err | output | 1 | Some stored receive entry is tagged |
| line_irq | output | 1 | Line-status interrupt |

## Verification
Two collisions matter most. The first is a new error event landing in the same cycle as a status read. The bench provokes it by pushing a tagged character with `early_err`=1 while strobing `lsr_rd`, and it expects `line_irq` to stay set. The second is a pop and a head-arrival event meeting across the receive queue. The bench sweeps the position of one bad character through every slot of a small queue in both timing modes. After each pop it expects the interrupt exactly when the popped count equals that slot, and it expects the error flag while the count is at or below it.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

  localparam int TAG_W = 3;

  // Tag bit order is externally visible: bit0 parity, bit1 framing, bit2 break.
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;

  function automatic logic tag_bad(input rx_tag_t t);
    return t.brk | t.frm | t.par;
  endfunction

  // Storage limit: full depth in queue mode, one entry as a holding register.
  function automatic int unsigned cap_of(input logic qmode, input int unsigned depth);
    return qmode ? depth : 1;
  endfunction

  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Counter step for simultaneous increment and decrement requests.
  function automatic int unsigned cnt_step(input int unsigned c, input logic inc, input logic dec);
    if (inc && !dec) return c + 1;
    if (dec && !inc) return c - 1;
    return c;
  endfunction

endpackage

// File: rtl/lsr_fifo.sv
module lsr_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] limit,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             pop_ok
);
  import uart_lsr_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign push_ok = push && (count < limit);
  assign pop_ok  = pop && (count != '0);
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= PTR_W'(ptr_next(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= PTR_W'(ptr_next(int'(rd_ptr), DEPTH));
      count <= CNT_W'(cnt_step(int'(count), push_ok, pop_ok));
    end
  end

endmodule

// File: rtl/lsr_tx_path.sv
module lsr_tx_path #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tsr_done,
  output logic [CNT_W-1:0]  tx_level,
  output logic [DATA_W-1:0] tx_shift_byte,
  output logic              thr_empty,
  output logic              tx_empty,
  output logic              tx_push_ok,
  output logic              tsr_load
);
  import uart_lsr_pkg::*;

  logic              tsr_busy;
  logic [DATA_W-1:0] head;
  logic              pop_ok;

  // Move the head into the shift register whenever it is free.
  assign tsr_load = !tsr_busy && (tx_level != '0);

  lsr_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk    (clk),
    .rst_n  (rst_n),
    .limit  (CNT_W'(cap_of(fifo_mode, DEPTH))),
    .push   (tx_wr),
    .wdata  (tx_wdata),
    .pop    (tsr_load),
    .rdata  (head),
    .count  (tx_level),
    .push_ok(tx_push_ok),
    .pop_ok (pop_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsr_busy      <= 1'b0;
      tx_shift_byte <= '0;
    end else if (pop_ok) begin
      tsr_busy      <= 1'b1;
      tx_shift_byte <= head;
    end else if (tsr_done) begin
      tsr_busy      <= 1'b0;
    end
  end

  assign thr_empty = (tx_level == '0);
  assign tx_empty  = thr_empty && !tsr_busy;

endmodule

// File: rtl/lsr_err_irq.sv
module lsr_err_irq #(
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic early_err,
  input  logic irq_en,
  input  logic lsr_rd,
  input  logic push_ok,
  input  logic push_bad,
  input  logic pop_ok,
  input  logic head_bad,
  input  logic rx_was_empty,
  output logic rx_fifo_err,
  output logic line_irq,
  output logic lsr_event
);
  import uart_lsr_pkg::*;

  logic [CNT_W-1:0] err_cnt;
  logic             head_seen;
  logic             pending;
  logic             head_event, arrive_event;

  assign arrive_event = early_err && push_ok && push_bad;
  assign head_event   = head_bad && !head_seen;
  assign lsr_event    = head_event || arrive_event;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt   <= '0;
      head_seen <= 1'b0;
      pending   <= 1'b0;
    end else begin
      err_cnt   <= CNT_W'(cnt_step(int'(err_cnt), push_ok && push_bad, pop_ok && head_bad));
      // A bad entry pushed into an empty queue with early timing is its own head event.
      head_seen <= !pop_ok && (head_seen || head_bad || (arrive_event && rx_was_empty));
      pending   <= lsr_event || (pending && !lsr_rd);
    end
  end

  assign rx_fifo_err = (err_cnt != '0);
  assign line_irq    = pending && irq_en;

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TAG_W = uart_lsr_pkg::TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              irq_en,
  input  logic              early_err,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tsr_done,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic [TAG_W-1:0]  rx_wtag,
  input  logic              rx_rd,
  input  logic              lsr_rd,
  output logic [CNT_W-1:0]  tx_level,
  output logic [DATA_W-1:0] tx_shift_byte,
  output logic              thr_empty,
  output logic              tx_empty,
  output logic [CNT_W-1:0]  rx_level,
  output logic [DATA_W-1:0] rx_rdata,
  output logic [TAG_W-1:0]  rx_rtag,
  output logic              rx_fifo_err,
  output logic              line_irq
);
  import uart_lsr_pkg::*;

  // Named internal events, observed by the bound checker.
  logic tx_push_ok, tsr_load;
  logic rx_push_ok, rx_pop_ok;
  logic head_bad, lsr_event;
  logic [DATA_W+TAG_W-1:0] rx_head;

  lsr_tx_path #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_mode    (fifo_mode),
    .tx_wr        (tx_wr),
    .tx_wdata     (tx_wdata),
    .tsr_done     (tsr_done),
    .tx_level     (tx_level),
    .tx_shift_byte(tx_shift_byte),
    .thr_empty    (thr_empty),
    .tx_empty     (tx_empty),
    .tx_push_ok   (tx_push_ok),
    .tsr_load     (tsr_load)
  );

  lsr_fifo #(.WIDTH(DATA_W + TAG_W), .DEPTH(DEPTH)) u_rxq (
    .clk    (clk),
    .rst_n  (rst_n),
    .limit  (CNT_W'(cap_of(fifo_mode, DEPTH))),
    .push   (rx_push),
    .wdata  ({rx_wtag, rx_wdata}),
    .pop    (rx_rd),
    .rdata  (rx_head),
    .count  (rx_level),
    .push_ok(rx_push_ok),
    .pop_ok (rx_pop_ok)
  );

  assign rx_rdata = rx_head[DATA_W-1:0];
  assign rx_rtag  = rx_head[DATA_W +: TAG_W];
  assign head_bad = (rx_level != '0) && tag_bad(rx_tag_t'(rx_rtag));

  lsr_err_irq #(.CNT_W(CNT_W)) u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .early_err   (early_err),
    .irq_en      (irq_en),
    .lsr_rd      (lsr_rd),
    .push_ok     (rx_push_ok),
    .push_bad    (tag_bad(rx_tag_t'(rx_wtag))),
    .pop_ok      (rx_pop_ok),
    .head_bad    (head_bad),
    .rx_was_empty(rx_level == '0),
    .rx_fifo_err (rx_fifo_err),
    .line_irq    (line_irq),
    .lsr_event   (lsr_event)
  );

endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en,
  input logic             lsr_rd,
  input logic             tx_push_ok,
  input logic             rx_push_ok,
  input logic             rx_pop_ok,
  input logic             lsr_event,
  input logic             thr_empty,
  input logic             tx_empty,
  input logic [CNT_W-1:0] rx_level,
  input logic [CNT_W-1:0] tx_level,
  input logic             rx_fifo_err,
  input logic             line_irq
);

  assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_ok |=> !thr_empty);

  assert_idle_implies_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty);

  assert_err_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_fifo_err) |-> $past(rx_push_ok));

  assert_err_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_fifo_err) |-> $past(rx_pop_ok));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> irq_en);

  assert_event_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_event |=> (line_irq || !irq_en));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !lsr_event) |=> !line_irq);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= CNT_W'(DEPTH)) && (tx_level <= CNT_W'(DEPTH)));

endmodule

bind uart_line_status uart_line_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_en     (irq_en),
  .lsr_rd     (lsr_rd),
  .tx_push_ok (tx_push_ok),
  .rx_push_ok (rx_push_ok),
  .rx_pop_ok  (rx_pop_ok),
  .lsr_event  (lsr_event),
  .thr_empty  (thr_empty),
  .tx_empty   (tx_empty),
  .rx_level   (rx_level),
  .tx_level   (tx_level),
  .rx_fifo_err(rx_fifo_err),
  .line_irq   (line_irq)
);

// File: tb/uart_line_status_test.sv
module uart_line_status_test;
  localparam int PERIOD = 10;
  localparam int D      = 8;
  localparam int DW     = 8;
  localparam int CW     = $clog2(D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b1, irq_en = 1'b1, early_err = 1'b0;
  logic tx_wr = 1'b0, tsr_done = 1'b0, rx_push = 1'b0, rx_rd = 1'b0, lsr_rd = 1'b0;
  logic [DW-1:0] tx_wdata = '0, rx_wdata = '0;
  logic [2:0] rx_wtag = '0;
  logic [CW-1:0] tx_level, rx_level;
  logic [DW-1:0] tx_shift_byte, rx_rdata;
  logic [2:0] rx_rtag;
  logic thr_empty, tx_empty, rx_fifo_err, line_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  uart_line_status #(.DATA_W(DW), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .irq_en(irq_en), .early_err(early_err),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tsr_done(tsr_done),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_wtag(rx_wtag), .rx_rd(rx_rd), .lsr_rd(lsr_rd),
    .tx_level(tx_level), .tx_shift_byte(tx_shift_byte), .thr_empty(thr_empty), .tx_empty(tx_empty),
    .rx_level(rx_level), .rx_rdata(rx_rdata), .rx_rtag(rx_rtag),
    .rx_fifo_err(rx_fifo_err), .line_irq(line_irq)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 thr_empty", thr_empty, 1);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rx_fifo_err", rx_fifo_err, 0);
    check("R1 line_irq", line_irq, 0);
    check("R1 levels", int'(tx_level) + int'(rx_level), 0);

    // R2/R4/R5: occupy the shift register, then fill the queue
    tx_wr = 1'b1; tx_wdata = 8'hA0; cyc(); tx_wr = 1'b0;
    check("R2 thr_empty after write", thr_empty, 0);
    check("R5 tx_empty after write", tx_empty, 0);
    cyc();
    check("R4 shift byte", tx_shift_byte, 8'hA0);
    check("R2 thr_empty after move", thr_empty, 1);
    check("R5 tx_empty busy shifter", tx_empty, 0);
    for (int k = 1; k <= D; k++) begin
      tx_wr = 1'b1; tx_wdata = DW'(k); cyc();
      check("R2 tx_level fill", tx_level, k);
      check("R2 thr_empty fill", thr_empty, 0);
    end
    tx_wr = 1'b1; tx_wdata = 8'hEE; cyc(); tx_wr = 1'b0;
    check("R10 tx write when full", tx_level, D);
    for (int k = 1; k <= D; k++) begin
      tsr_done = 1'b1; cyc(); tsr_done = 1'b0;
      cyc();
      check("R4 drain order", tx_shift_byte, k);
      check("R2 tx_level drain", tx_level, D - k);
      check("R2 thr_empty drain", thr_empty, (k == D) ? 1 : 0);
      check("R5 tx_empty drain", tx_empty, 0);
    end
    tsr_done = 1'b1; cyc(); tsr_done = 1'b0;
    check("R5 tx_empty idle", tx_empty, 1);

    // R3 holding-register mode
    fifo_mode = 1'b0;
    tx_wr = 1'b1; tx_wdata = 8'h11; cyc(); tx_wr = 1'b0;
    check("R3 thr clears on write", thr_empty, 0);
    cyc();
    check("R3 thr sets on move", thr_empty, 1);
    tx_wr = 1'b1; tx_wdata = 8'h22; cyc();
    check("R3 holding full", tx_level, 1);
    tx_wdata = 8'h33; cyc(); tx_wr = 1'b0;
    check("R3 second write ignored", tx_level, 1);
    tsr_done = 1'b1; cyc(); tsr_done = 1'b0;
    cyc();
    check("R3 held byte kept", tx_shift_byte, 8'h22);
    check("R3 thr after move", thr_empty, 1);
    tsr_done = 1'b1; cyc(); tsr_done = 1'b0;
    check("R5 idle in holding mode", tx_empty, 1);
    fifo_mode = 1'b1;

    // R6/R8/R9/R12 sweep: one bad entry at every slot, both timing modes
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < D; p++) begin
        early_err = m[0];
        for (int j = 0; j < D; j++) begin
          rx_push = 1'b1; rx_wdata = DW'(j);
          rx_wtag = (j == p) ? 3'(1 << (p % 3)) : 3'b000;
          cyc();
        end
        rx_push = 1'b0; rx_wtag = '0;
        check(m ? "R9 early irq" : "R8 head irq at load", line_irq, (m == 1 || p == 0) ? 1 : 0);
        check("R6 err after fill", rx_fifo_err, 1);
        lsr_rd = 1'b1; cyc(); lsr_rd = 1'b0;
        check("R9 read clears irq", line_irq, 0);
        rx_push = 1'b1; rx_wtag = 3'b100; cyc(); rx_push = 1'b0; rx_wtag = '0;
        check("R10 rx push when full", rx_level, D);
        check("R10 rejected bad push no irq", line_irq, 0);
        for (int i = 1; i <= D; i++) begin
          check("R12 rx order", rx_rdata, i - 1);
          rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
          cyc();
          check(m ? "R9 head refire" : "R8 head event", line_irq, (i == p) ? 1 : 0);
          check("R6 err tracks contents", rx_fifo_err, (i <= p) ? 1 : 0);
          if (i < D) check("R6 head tag position", rx_rtag, (i == p) ? (1 << (p % 3)) : 0);
          lsr_rd = 1'b1; cyc(); lsr_rd = 1'b0;
        end
        rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
        check("R10 pop empty level", rx_level, 0);
        check("R10 pop empty err", rx_fifo_err, 0);
        check("R10 pop empty irq", line_irq, 0);
      end
    end

    // R7 enable gating with a pending event
    early_err = 1'b0; irq_en = 1'b0;
    rx_push = 1'b1; rx_wdata = 8'h5A; rx_wtag = 3'b010; cyc(); rx_push = 1'b0; rx_wtag = '0;
    cyc();
    check("R7 irq masked", line_irq, 0);
    check("R6 err while masked", rx_fifo_err, 1);
    irq_en = 1'b1; cyc();
    check("R7 pending shows on enable", line_irq, 1);
    lsr_rd = 1'b1; rx_rd = 1'b1; cyc(); lsr_rd = 1'b0; rx_rd = 1'b0;
    check("R6 err clears on pop", rx_fifo_err, 0);
    check("R7 cleared", line_irq, 0);

    // R11 event and status read in the same cycle
    early_err = 1'b1;
    rx_push = 1'b1; rx_wdata = 8'h77; rx_wtag = 3'b001; lsr_rd = 1'b1; cyc();
    rx_push = 1'b0; rx_wtag = '0; lsr_rd = 1'b0;
    check("R11 event wins over read", line_irq, 1);
    lsr_rd = 1'b1; cyc(); lsr_rd = 1'b0;
    check("R9 single event into empty queue", line_irq, 0);
    cyc();
    check("R9 no refire when already head", line_irq, 0);
    rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
    check("R6 err clear final", rx_fifo_err, 0);

    finish_run();
  end
endmodule